// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a small synchronous static memory whose pipeline lets reads and writes follow each other on consecutive clock edges with no idle cycle between them. Every word is split into byte lanes of nine bits: eight data bits plus one parity bit. An access is started on a "load" edge, which carries an external address and a read or write command. An "advance" edge instead steps a two-bit burst counter and continues the loaded command at the next word of an aligned group of four. The order within that group is either linear or interleaved, and a strap input selects which.

Read data is registered. It appears on the output after the qualifying edge that follows the address edge. Write data and the per-lane byte-write enables are taken two qualifying edges after the address edge. A read that lands on a write whose data arrives on that same edge returns the new bytes, merged lane by lane with the stored word.

An active-low clock enable freezes the whole block. The output-drive flag is raised only for read data while the output enable is low. The bidirectional data pins are split into a data-in port, a data-out port and a drive flag.

Top module: `pipeSram`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge) the drive flag dOutEn is low, and no read or write is pending.
- R2: A load edge (advLd=0) starts an access only when ce1N=0, ce2=1 and ce3N=0 are all true at that edge. Any other chip-enable combination deselects the block, and dOutEn is then low after the next qualifying edge.
- R3: A read loaded (weN=1) or advanced at qualifying edge k places the word at its address on dOut after qualifying edge k+1. dOutEn is high in that cycle when oeN is low.
- R4: A write loaded (weN=0) or advanced at qualifying edge k takes dIn and bwN at qualifying edge k+2. Reads and writes may be loaded on back-to-back edges in any mix.
- R5: Byte-write bit bwN[i]=0 writes lane i, which is dIn bits [9i+8:9i], with bit 9i+8 as that lane's parity bit. Lanes with bwN[i]=1 keep their stored value.
- R6: With modeIlv=0, the n-th advance after a load at address a uses low bits (a[1:0]+n) mod 4, and the upper address bits stay unchanged.
- R7: With modeIlv=1, the n-th advance after a load at address a uses low bits a[1:0] XOR n, and the upper address bits stay unchanged.
- R8: An edge with clkEnN=1 is ignored. dOut, dOutEn, the memory, the burst counter and all pending accesses hold.
- R9: dOutEn is low whenever oeN is high. It is also low in the cycle after a write's first qualifying edge (the write data phase).
- R10: A read at edge k+1 of a word written at edge k returns, for each lane enabled by bwN, the new byte, and the stored byte for the other lanes.
- R11: An advance edge continues the last loaded command. After a deselecting load, an advance edge performs no access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| advLd | input | 1 | 1 = advance burst, 0 = load address and command |
| weN | input | 1 | Write enable at a load edge, active low |
| bwN | input | LANES | Per-lane byte-write enables, active low |
| modeIlv | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dIn | input | LANES*LANE_W | Write data |
| dOut | output | LANES*LANE_W | Registered read data |
| dOutEn | output | 1 | Output drive flag |

## Verification
The bench builds the block with its default parameters: ADDR_W=6, LANES=4 and LANE_W=9, which gives 64 words of 36 bits. At that depth the bench can write every word first, so every later read has a known reference value. It also leaves room for bursts in several four-word groups, where the wrap and the unchanged upper address bits can be seen. Four lanes are enough to apply partial byte-write patterns that include the parity bit of each lane.

// File: rtl/pipeSramPkg.sv
`timescale 1ns/1ps
package pipeSramPkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic step;    // qualifying edge
    logic rdNow;   // stage-1 holds a read
    logic wrNow;   // stage-2 write completes at this edge
    logic fwdHit;  // stage-1 read hits stage-2 write
  } strobeT;

  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] count,
                                          input logic       ilv);
    return ilv ? (start ^ count) : (start + count);
  endfunction

endpackage

// File: rtl/sramCtrl.sv
`timescale 1ns/1ps
module sramCtrl
  import pipeSramPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advLd,
  input  logic              weN,
  input  logic              modeIlv,
  input  logic [ADDR_W-1:0] addrIn,
  output strobeT            strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr
);

  logic              selected;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        burstCnt;
  logic [1:0]        nextCnt;
  opKindT            curOp;
  opKindT            newOp;
  logic [ADDR_W-1:0] newAddr;

  opKindT            s1Op;
  opKindT            s2Op;
  logic [ADDR_W-1:0] s1Addr;
  logic [ADDR_W-1:0] s2Addr;

  assign selected = !ce1N && ce2 && !ce3N;
  assign nextCnt  = burstCnt + 2'd1;

  always_comb begin
    if (!advLd) begin
      newOp   = selected ? (weN ? OP_READ : OP_WRITE) : OP_IDLE;
      newAddr = addrIn;
    end else begin
      newOp   = curOp;
      newAddr = {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], nextCnt, modeIlv)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      burstCnt <= '0;
      curOp    <= OP_IDLE;
      s1Op     <= OP_IDLE;
      s2Op     <= OP_IDLE;
      s1Addr   <= '0;
      s2Addr   <= '0;
    end else if (!clkEnN) begin
      if (!advLd) begin
        baseAddr <= addrIn;
        burstCnt <= '0;
        curOp    <= newOp;
      end else begin
        burstCnt <= nextCnt;
      end
      s1Op   <= newOp;
      s1Addr <= newAddr;
      s2Op   <= s1Op;
      s2Addr <= s1Addr;
    end
  end

  assign strb.step   = !clkEnN;
  assign strb.rdNow  = (s1Op == OP_READ);
  assign strb.wrNow  = !clkEnN && (s2Op == OP_WRITE);
  assign strb.fwdHit = (s1Op == OP_READ) && (s2Op == OP_WRITE) && (s1Addr == s2Addr);
  assign rdAddr      = s1Addr;
  assign wrAddr      = s2Addr;

endmodule

// File: rtl/sramDatapath.sv
`timescale 1ns/1ps
module sramDatapath
  import pipeSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strb,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        bwN,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] rawWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] dataReg;
  logic              driveReg;

  assign rawWord = memArr[rdAddr];

  // per-lane bypass of a write completing on this edge
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      mergedWord[l*LANE_W +: LANE_W] = (strb.fwdHit && !bwN[l])
                                       ? dIn[l*LANE_W +: LANE_W]
                                       : rawWord[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrNow) begin
      for (int l = 0; l < LANES; l++) begin
        if (!bwN[l]) memArr[wrAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      driveReg <= 1'b0;
    end else if (strb.step) begin
      driveReg <= strb.rdNow;
      if (strb.rdNow) dataReg <= mergedWord;
    end
  end

  assign dOut   = dataReg;
  assign dOutEn = driveReg && !oeN;

endmodule

// File: rtl/pipeSram.sv
`timescale 1ns/1ps
module pipeSram
  import pipeSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    advLd,
  input  logic                    weN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    modeIlv,
  input  logic                    oeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);

  localparam int DATA_W = LANES * LANE_W;

  strobeT            strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;

  sramCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLd(advLd), .weN(weN), .modeIlv(modeIlv), .addrIn(addr),
    .strb(strb), .rdAddr(rdAddr), .wrAddr(wrAddr)
  );

  sramDatapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdAddr(rdAddr), .wrAddr(wrAddr),
    .bwN(bwN), .dIn(dIn), .oeN(oeN),
    .dOut(dOut), .dOutEn(dOutEn)
  );

endmodule

// File: rtl/pipeSramChk.sv
`timescale 1ns/1ps
module pipeSramChk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              advLd,
  input logic              weN,
  input logic [DATA_W-1:0] dOut,
  input logic              dOutEn,
  input logic [ADDR_W-1:0] rdAddr
);

  logic selNow;
  assign selNow = !ce1N && ce2 && !ce3N;

  // R8: a masked edge freezes read data and the stage-1 address
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(dOut) && $stable(rdAddr)));

  // R2: a deselecting load leaves the driver off after the next qualifying edge
  a_r2_deselect_off: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLd && !selNow) ##1 !clkEnN |=> !dOutEn);

  // R9: write data phase keeps the driver off
  a_r9_write_phase_off: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLd && selNow && !weN) ##1 !clkEnN |=> !dOutEn);

  // R6/R7: an advance stays inside the aligned four-word group
  a_r6_burst_in_group: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLd) |=> (rdAddr[ADDR_W-1:2] == $past(rdAddr[ADDR_W-1:2])));

endmodule

bind pipeSram pipeSramChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
  .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
  .advLd(advLd), .weN(weN),
  .dOut(dOut), .dOutEn(dOutEn), .rdAddr(rdAddr)
);

// File: tb/pipeSram_tb.sv
`timescale 1ns/1ps
module pipeSram_tb_top;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              clkEnN, ce1N, ce2, ce3N, advLd, weN, modeIlv, oeN;
  logic [LANES-1:0]  bwN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dIn;
  logic [DATA_W-1:0] dOut;
  logic              dOutEn;

  always #5 clk = ~clk;

  pipeSram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLd(advLd), .weN(weN), .bwN(bwN), .modeIlv(modeIlv), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  typedef struct packed {
    logic              isRd;
    logic [ADDR_W-1:0] addr;
  } itemT;

  typedef struct packed {
    logic              isWr;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  bw;
    logic [DATA_W-1:0] data;
  } pendT;

  itemT              expQ[$];
  string             tagQ[$];
  logic [DATA_W-1:0] refMem [DEPTH];
  pendT              p1, p2;
  logic [ADDR_W-1:0] bBase;
  logic [1:0]        bCnt;
  int                bOp;      // 0 idle, 1 read, 2 write
  int                seq;
  int                nChecks, nErr;
  bit                running, lastQual;
  logic [DATA_W-1:0] prevOut;
  logic              prevEn;

  function automatic logic [DATA_W-1:0] mix(input int n);
    logic [63:0] v;
    v = 64'(n + 1) * 64'h9E3779B97F4A7C15;
    return v[47:12];
  endfunction

  function automatic logic [ADDR_W-1:0] seqAddr(input logic [ADDR_W-1:0] b,
                                               input logic [1:0] c, input logic ilv);
    logic [1:0] low;
    if (ilv) low = b[1:0] ^ c;
    else     low = b[1:0] + c;
    return {b[ADDR_W-1:2], low};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one qualifying edge
  task automatic stepQ(input logic ld, input logic c1n, input logic c2, input logic c3n,
                       input logic wen, input logic [ADDR_W-1:0] a,
                       input logic [LANES-1:0] bw, input string tag);
    pendT np;
    itemT it;
    logic [ADDR_W-1:0] ea;
    clkEnN = 1'b0; advLd = ld; ce1N = c1n; ce2 = c2; ce3N = c3n; weN = wen; addr = a;
    dIn = p2.isWr ? p2.data : ~mix(seq + 7);
    bwN = p2.isWr ? p2.bw : 4'b0000;
    @(posedge clk); #2;
    if (p2.isWr)
      for (int l = 0; l < LANES; l++)
        if (!p2.bw[l]) refMem[p2.addr][l*LANE_W +: LANE_W] = p2.data[l*LANE_W +: LANE_W];
    if (!ld) begin
      bBase = a; bCnt = 2'd0; ea = a;
      if (!c1n && c2 && !c3n) bOp = wen ? 1 : 2;
      else bOp = 0;
    end else begin
      bCnt = bCnt + 2'd1;
      ea = seqAddr(bBase, bCnt, modeIlv);
    end
    it.isRd = (bOp == 1); it.addr = ea;
    np.isWr = (bOp == 2); np.addr = ea; np.bw = bw; np.data = mix(seq);
    seq++;
    expQ.push_back(it); tagQ.push_back(tag);
    p2 = p1; p1 = np;
    lastQual = 1'b1; running = 1'b1;
  endtask

  // masked edge with junk on every input
  task automatic stall();
    clkEnN = 1'b1; advLd = ~advLd; weN = 1'b0; ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    addr = ~addr; dIn = mix(seq + 99); bwN = 4'b0000;
    @(posedge clk); #2;
    lastQual = 1'b0;
  endtask

  task automatic rdLoad(input logic [ADDR_W-1:0] a, input string tag);
    stepQ(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, 4'hF, tag);
  endtask
  task automatic wrLoad(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] bw, input string tag);
    stepQ(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, bw, tag);
  endtask
  task automatic adv(input logic [LANES-1:0] bw, input string tag);
    stepQ(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, bw, tag);
  endtask
  task automatic desel(input logic c1n, input logic c2, input logic c3n, input string tag);
    stepQ(1'b0, c1n, c2, c3n, 1'b1, '0, 4'hF, tag);
  endtask

  // monitor: scoreboard pop after each qualifying edge, hold check after stalls
  always @(negedge clk) begin
    if (running) begin
      if (lastQual) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 queue empty", 64'd0, 64'd1);
        end else begin
          itemT it;
          string tg;
          logic expEn;
          it = expQ.pop_front();
          tg = tagQ.pop_front();
          expEn = it.isRd && !oeN;
          chk(dOutEn === expEn, {tg, " dOutEn"}, 64'(dOutEn), 64'(expEn));
          if (it.isRd)
            chk(dOut === refMem[it.addr], {tg, " dOut"}, 64'(dOut), 64'(refMem[it.addr]));
        end
      end else begin
        chk(dOut === prevOut && dOutEn === prevEn, "R8 stall hold",
            64'({dOutEn, dOut}), 64'({prevEn, prevOut}));
      end
      prevOut = dOut;
      prevEn  = dOutEn;
    end
  end

  initial begin
    #1_000_000;
    nErr++; nChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    nChecks = 0; nErr = 0; seq = 0; running = 1'b0; lastQual = 1'b0;
    p1 = '0; p2 = '0; bBase = '0; bCnt = '0; bOp = 0;
    rstN = 1'b0; clkEnN = 1'b0; advLd = 1'b0; ce1N = 1'b1; ce2 = 1'b0; ce3N = 1'b1;
    weN = 1'b1; bwN = 4'hF; modeIlv = 1'b1; oeN = 1'b0; addr = '0; dIn = '0;
    expQ.push_back('0); tagQ.push_back("R1");
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    #1 chk(dOutEn === 1'b0, "R1 reset dOutEn", 64'(dOutEn), 64'd0);

    // fill every word, full lanes (R4)
    for (int a = 0; a < DEPTH; a++) wrLoad(ADDR_W'(a), 4'b0000, "R4 fill");
    desel(1'b1, 1'b1, 1'b0, "R2");
    desel(1'b1, 1'b1, 1'b0, "R2");
    for (int a = 0; a < DEPTH; a++) rdLoad(ADDR_W'(a), "R3");

    // back-to-back mixed traffic with partial lanes and forwarding
    for (int i = 0; i < 16; i++) begin
      rdLoad(ADDR_W'(i * 3), "R3");
      wrLoad(ADDR_W'(i * 3), 4'(i), "R5");
      rdLoad(ADDR_W'(i * 3), "R10");
      wrLoad(ADDR_W'(i * 3 + 1), 4'(~i), "R4");
      rdLoad(ADDR_W'(i * 3 + 1), "R10");
      rdLoad(ADDR_W'(i * 3), "R5");
    end

    // linear bursts with stalls mid-burst (R6)
    modeIlv = 1'b0;
    rdLoad(6'h15, "R6");
    adv(4'hF, "R6"); stall(); stall(); adv(4'hF, "R6"); adv(4'hF, "R6");
    wrLoad(6'h2E, 4'b0000, "R6");
    adv(4'b0101, "R6"); stall(); adv(4'b0000, "R6"); adv(4'b1110, "R6");
    rdLoad(6'h2C, "R6");
    adv(4'hF, "R6"); adv(4'hF, "R6"); adv(4'hF, "R6"); adv(4'hF, "R11 wrap");

    // interleaved bursts (R7)
    modeIlv = 1'b1;
    rdLoad(6'h1B, "R7");
    adv(4'hF, "R7"); adv(4'hF, "R7"); stall(); adv(4'hF, "R7");
    wrLoad(6'h36, 4'b0000, "R7");
    adv(4'b0011, "R7"); adv(4'b0000, "R7"); stall(); stall(); adv(4'b1000, "R7");
    rdLoad(6'h35, "R7");
    adv(4'hF, "R7"); adv(4'hF, "R7"); adv(4'hF, "R7");

    // deselect patterns, advance after deselect
    desel(1'b1, 1'b1, 1'b0, "R2");
    desel(1'b0, 1'b0, 1'b0, "R2");
    desel(1'b0, 1'b1, 1'b1, "R2");
    adv(4'hF, "R11");
    adv(4'hF, "R11");
    rdLoad(6'h09, "R11");
    adv(4'hF, "R11");

    // output enable masking
    oeN = 1'b1;
    rdLoad(6'h0A, "R9");
    rdLoad(6'h0B, "R9");
    oeN = 1'b0;
    rdLoad(6'h0C, "R9");

    // pending write across stalls, junk ignored
    wrLoad(6'h05, 4'b0000, "R8");
    stall(); stall();
    rdLoad(6'h05, "R8");
    stall();
    desel(1'b1, 1'b0, 1'b1, "R2");
    rdLoad(6'h05, "R8");
    desel(1'b1, 1'b0, 1'b1, "R2");
    desel(1'b1, 1'b0, 1'b1, "R2");
    @(negedge clk);
    running = 1'b0;

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule